// File: doc/BRIEF.md
# MDIO Station-Management Master

This block reads and writes PHY registers over the two-wire MDC/MDIO management interface. A one-cycle command strobe carries the direction, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The block then runs a complete management frame on the wire and raises `busy` until the last bit has finished. On a read, the 16 bits returned by the PHY appear on `rd_data` as `busy` falls.

MDC comes from the system clock. Its period is a runtime divisor field plus one, so the management clock can stay within the slow rate that most PHYs guarantee, or run faster for a PHY that accepts it. A second runtime setting selects one of two frame starts:
- a 32-bit all-ones preamble before the start delimiter, or
- no preamble, so the frame opens with the start delimiter.

Both settings sit in a small configuration register loaded through `cfg_we`. The block takes a snapshot of them when it accepts a command.

MDIO is presented as an output, an output-enable and a sampled input. An external tristate buffer with a pull-up forms the shared line.

Top module: `mdio_master`

## Requirements
- R1: The MDC period is (divisor field + 1) system clocks. A divisor field of 0 is treated as 1, which gives a period of 2 clocks. MDC is low for the first ceil(period/2) clocks of each period and high for the rest.
- R2: After reset the divisor field is 7, so MDC runs at one eighth of the clock. Preamble suppression is also set after reset.
- R3: With preamble suppression clear, the master drives 32 consecutive ones on MDIO, one per MDC cycle, before the start delimiter. The frame then lasts 64 MDC cycles.
- R4: With preamble suppression set, the first MDC cycle carries the first start bit (0). The frame lasts 32 MDC cycles.
- R5: After any preamble, the frame carries these fields, MSB first:
  - start bits 0 then 1;
  - opcode, 01 for write and 10 for read;
  - 5-bit PHY address;
  - 5-bit register address;
  - two turnaround bits, driven as 1 then 0 on a write;
  - 16 data bits.
- R6: On a read, the output-enable is low from the first turnaround bit to the end of the frame. MDIO is sampled on each rising MDC edge of the 16 data bits. The data is presented MSB first on `rd_data` when `busy` falls, and `rd_data` holds until the next read completes.
- R7: During a frame, `mdio_o` changes only on the clock edge where MDC falls.
- R8: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly (frame MDC cycles) x (divisor + 1) clocks. A `cmd_valid` while `busy` is high is ignored and does not alter the running frame.
- R9: Whenever `busy` is low, MDC is low and `mdio_oe` is low. This includes the state out of reset.
- R10: `cfg_we` loads `cfg_div` and `cfg_pre_off` at any time. Each command uses the values held on its acceptance edge, so a write during a frame does not change that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_div | input | DIV_W | Divisor field; the MDC period is this value + 1 |
| cfg_pre_off | input | 1 | 1 = no preamble, 0 = 32-bit preamble |
| cmd_valid | input | 1 | Command strobe |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | A frame is in progress |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven onto MDIO |
| mdio_oe | output | 1 | MDIO output-enable |
| mdio_i | input | 1 | Sampled MDIO line |

## Verification
The assertions check these properties on every cycle:
- the line is quiet while idle;
- `mdio_o` moves only on falling MDC edges;
- each MDC high phase ends at a fall;
- the output-enable stays released through the read turnaround and data;
- read data holds while a frame runs;
- a command that arrives while busy leaves the running frame untouched.

Only the bench's scenarios can show the following:
- the exact bit sequence, with and without preamble;
- the MDC period for each divisor, including the clamp of field 0;
- the length of the busy window;
- the values taken after reset;
- that data returned by a PHY model arrives intact on `rd_data`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  // Leading frame bits the master always drives: start, opcode, addresses.
  localparam int HDR_LEN   = FRAME_LEN - DATA_W - 2;

  typedef enum logic [1:0] {
    OPC_WRITE = 2'b01,
    OPC_READ  = 2'b10
  } mdio_opc_e;

  function automatic logic [FRAME_LEN-1:0] make_frame(
    input logic              rd,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] wd
  );
    mdio_opc_e opc;
    opc = rd ? OPC_READ : OPC_WRITE;
    return {2'b01, opc, phy, regad, (rd ? 2'b00 : 2'b10), (rd ? {DATA_W{1'b0}} : wd)};
  endfunction

  function automatic logic [FRAME_LEN-1:0] make_oe_mask(input logic rd);
    return {{HDR_LEN{1'b1}}, {(DATA_W + 2){~rd}}};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] rise_at;
  logic [DIV_W-1:0] cnt;

  // Field 0 would mean a period of one clock, which cannot toggle; clamp to 1.
  assign div_eff  = (div_in == '0) ? DIV_W'(1) : div_in;
  assign rise_stb = run && (cnt == rise_at);
  assign fall_stb = run && (cnt == div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(1);
      rise_at <= '0;
      cnt     <= '0;
      mdc     <= 1'b0;
    end else if (start) begin
      div_q   <= div_eff;
      rise_at <= div_eff >> 1;  // low phase = ceil((div+1)/2) clocks
      cnt     <= '0;
      mdc     <= 1'b0;
    end else if (run) begin
      if (fall_stb) begin
        cnt <= '0;
        mdc <= 1'b0;
      end else begin
        cnt <= cnt + DIV_W'(1);
        if (rise_stb) mdc <= 1'b1;
      end
    end else begin
      cnt <= '0;
      mdc <= 1'b0;
    end
  end

  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall_stb |-> mdc);  // R1
  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    rise_stb |-> !mdc);  // R1
  AST_MDC_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |-> !mdc);  // R9

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              pre_off,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              start,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rd_data
);

  localparam int TOT   = PRE_LEN + FRAME_LEN;
  localparam int CNT_W = $clog2(TOT + 1);

  logic [FRAME_LEN-1:0] frame_w;
  logic [FRAME_LEN-1:0] mask_w;
  logic [TOT-1:0]       load_sh;
  logic [TOT-1:0]       load_oe;
  logic [CNT_W-1:0]     load_rem;
  logic [TOT-1:0]       sh;
  logic [TOT-1:0]       oe_sh;
  logic [CNT_W-1:0]     rem;
  logic                 is_rd;
  logic [DATA_W-1:0]    rx;
  logic                 in_data;

  assign start   = cmd_valid && !busy;
  assign frame_w = make_frame(cmd_read, cmd_phy, cmd_reg, cmd_wdata);
  assign mask_w  = make_oe_mask(cmd_read);
  assign in_data = (rem <= CNT_W'(DATA_W));

  always_comb begin
    if (pre_off) begin
      load_sh  = {frame_w, {PRE_LEN{1'b0}}};
      load_oe  = {mask_w, {PRE_LEN{1'b0}}};
      load_rem = CNT_W'(FRAME_LEN);
    end else begin
      load_sh  = {{PRE_LEN{1'b1}}, frame_w};
      load_oe  = {{PRE_LEN{1'b1}}, mask_w};
      load_rem = CNT_W'(TOT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sh      <= '0;
      oe_sh   <= '0;
      rem     <= '0;
      is_rd   <= 1'b0;
      rx      <= '0;
      rd_data <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      sh      <= load_sh;
      oe_sh   <= load_oe;
      rem     <= load_rem;
      is_rd   <= cmd_read;
      mdio_o  <= load_sh[TOT-1];
      mdio_oe <= load_oe[TOT-1];
    end else if (busy) begin
      if (rise_stb && is_rd && in_data) rx <= {rx[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (rem == CNT_W'(1)) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) rd_data <= rx;
        end else begin
          sh      <= {sh[TOT-2:0], 1'b0};
          oe_sh   <= {oe_sh[TOT-2:0], 1'b0};
          rem     <= rem - CNT_W'(1);
          mdio_o  <= sh[TOT-2];
          mdio_oe <= oe_sh[TOT-2];
        end
      end
    end
  end

  AST_OE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);  // R9
  AST_BIT_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_stb));  // R7
  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (busy && is_rd && rem <= CNT_W'(DATA_W + 2)) |-> !mdio_oe);  // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd_data));  // R6
  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid && !fall_stb) |=> (busy && $stable(is_rd) && $stable(rem)));  // R8

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int DIV_RST     = 7,
  parameter bit PRE_OFF_RST = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_pre_off,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  logic [DIV_W-1:0] div_r;
  logic             pre_off_r;
  logic             start;
  logic             rise_stb;
  logic             fall_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_r     <= DIV_W'(DIV_RST);
      pre_off_r <= PRE_OFF_RST;
    end else if (cfg_we) begin
      div_r     <= cfg_div;
      pre_off_r <= cfg_pre_off;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .run      (busy),
    .div_in   (div_r),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_read  (cmd_read),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .pre_off   (pre_off_r),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .start     (start),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_data   (rd_data)
  );

  AST_MDIO_ON_MDC_FALL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));  // R7
  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));  // R9

endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_div = '0;
  logic        cfg_pre_off = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [4:0]  cmd_phy = '0;
  logic [4:0]  cmd_reg = '0;
  logic [15:0] cmd_wdata = '0;
  logic        busy, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rd_data;

  logic        phy_oe = 1'b0;
  logic        phy_bit = 1'b0;
  logic        mdio_line;

  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  logic [63:0] got_bits;
  logic [63:0] got_oe;
  int          rc = 0;
  time         t_rise0, t_rise1;
  int          exp_nb = 32;
  bit          mon_read = 1'b0;
  logic [15:0] phy_data = '0;
  logic [15:0] last_rd = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_bit : 1'b1);
  assign mdio_i    = mdio_line;

  mdio_master uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_pre_off(cfg_pre_off),
    .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .busy(busy), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Wire monitor: what a PHY sees on each rising MDC edge.
  always @(posedge mdc) begin
    if (rc < 64) begin
      got_bits[63 - rc] = mdio_line;
      got_oe[63 - rc]   = mdio_oe;
    end
    if (rc == 0) t_rise0 = $time;
    if (rc == 1) t_rise1 = $time;
    rc++;
  end

  // PHY model: drives turnaround 0 and data after falling edges on reads.
  always @(negedge mdc) begin
    if (mon_read && rc >= exp_nb - 17 && rc < exp_nb) begin
      phy_oe  = 1'b1;
      phy_bit = (rc == exp_nb - 17) ? 1'b0 : phy_data[15 - (rc - (exp_nb - 16))];
    end else begin
      phy_oe = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input int div, input bit pre_off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 8'(div); cfg_pre_off = pre_off;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_op(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input int div, input bit pre_off,
                        input bit interfere);
    int          eff;
    int          nb;
    int          cycles;
    int          period;
    logic [31:0] fr;
    logic [31:0] msk;
    logic [63:0] exp_bits;
    logic [63:0] exp_oe;
    eff      = (div == 0) ? 1 : div;
    nb       = pre_off ? 32 : 64;
    fr       = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, wd};
    msk      = rd ? {14'h3FFF, 18'h0} : 32'hFFFF_FFFF;
    exp_bits = pre_off ? {fr, 32'h0} : {32'hFFFF_FFFF, fr};
    exp_oe   = pre_off ? {msk, 32'h0} : {32'hFFFF_FFFF, msk};
    got_bits = '0;
    got_oe   = '0;
    rc       = 0;
    exp_nb   = nb;
    mon_read = rd;
    phy_data = wd;

    @(negedge clk);
    cmd_valid = 1'b1; cmd_read = rd; cmd_phy = phy; cmd_reg = ra; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    cycles = 0;
    while (busy && cycles < 5000) begin
      cycles++;
      if (interfere && cycles == 20) begin
        // R8 stray command, R10 config write mid-frame
        cmd_valid = 1'b1; cmd_read = ~rd; cmd_phy = ~phy; cmd_wdata = ~wd;
        cfg_we = 1'b1; cfg_div = 8'd0; cfg_pre_off = ~pre_off;
      end
      if (interfere && cycles == 21) begin
        cmd_valid = 1'b0; cfg_we = 1'b0;
      end
      @(negedge clk);
    end
    cmd_valid = 1'b0; cfg_we = 1'b0;

    check(cycles == nb * (eff + 1), "R8", "busy length", 64'(cycles), 64'(nb * (eff + 1)));
    check(rc == nb, pre_off ? "R4" : "R3", "MDC cycles per frame", 64'(rc), 64'(nb));
    check(got_bits == exp_bits, "R5", "wire bits", got_bits, exp_bits);
    check(got_oe == exp_oe, rd ? "R6" : "R5", "output-enable pattern", got_oe, exp_oe);
    period = int'((t_rise1 - t_rise0) / CLK_PERIOD);
    check(period == eff + 1, "R1", "MDC period", 64'(period), 64'(eff + 1));
    if (rd) last_rd = wd;
    check(rd_data == last_rd, "R6", "read data", 64'(rd_data), 64'(last_rd));
    check(!mdc && !mdio_oe, "R9", "idle after frame", {62'b0, mdc, mdio_oe}, 64'h0);
    if (interfere) begin
      check(!busy && rc == nb, "R8", "stray command ignored", 64'(rc), 64'(nb));
      check(period == eff + 1 && cycles == nb * (eff + 1), "R10",
            "config held for frame", 64'(cycles), 64'(nb * (eff + 1)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R9", "reset state",
          {61'b0, busy, mdc, mdio_oe}, 64'h0);

    // R2: first command with reset configuration: divide by 8, no preamble
    run_op(1'b0, 5'h11, 5'h02, 16'hBEEF, 7, 1'b1, 1'b0);
    check(rc == 32, "R2", "default suppresses preamble", 64'(rc), 64'd32);
    check(int'((t_rise1 - t_rise0) / CLK_PERIOD) == 8, "R2", "default MDC period",
          64'((t_rise1 - t_rise0) / CLK_PERIOD), 64'd8);

    foreach (uut.rd_data[i]) begin end
    for (int d = 0; d < 5; d++) begin
      for (int p = 0; p < 2; p++) begin
        for (int r = 0; r < 2; r++) begin
          int div;
          div = (d == 4) ? 7 : d;
          write_cfg(div, p[0]);
          run_op(r[0], 5'(d * 7 + p * 3 + r), 5'(31 - d * 5 - r),
                 16'hA5C3 ^ 16'(div << 9) ^ 16'(p * 16'h0F0F) ^ 16'(r * 16'h1234),
                 div, p[0], d == 2);
        end
      end
    end

    // R6: write after a read leaves rd_data intact
    write_cfg(1, 1'b1);
    run_op(1'b1, 5'h1F, 5'h00, 16'h8001, 1, 1'b1, 1'b0);
    run_op(1'b0, 5'h00, 5'h1F, 16'h7FFE, 1, 1'b1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule